// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is a single DMA channel that walks a chain of transfer descriptors kept in memory. Software loads the first descriptor straight into the channel's registers (next link, byte count, source, destination, configuration) and writes the configuration word with its enable bit set. The channel then copies the counted bytes element by element from the source address to the destination address. Each element is one read beat followed by one write beat on a simple memory master port. The addresses advance as the configuration asks.

When a segment's count is used up, the channel checks the link word. If link bit 1 is set, it fetches the next descriptor from the 32-byte-aligned address the link gives and carries on. Otherwise the chain is over: the channel raises a one-cycle completion pulse and drops its enable bit. A memory error response stops the channel with a one-cycle error pulse. Software can stop the channel at any time by clearing the enable bit.

Top module: `lldma_channel`

## Requirements
- R1: After reset, the link, count, source, destination, configuration and status registers all read 0. `busy` is low, and `mem_req`, `xfer_done` and `xfer_err` are low.
- R2: The count register (offset 0x10) keeps only 13 bits, so the largest count is 0x1FFF. Reading it returns the value in bits 12:0 with zeros above, so writing 0xFFFF reads back 0x1FFF.
- R3: While idle, a write to the configuration register (offset 0x1C) with bit 0 set starts the channel. From then on `busy` and bit 0 of the status register (offset 0x20) read 1 until the channel stops.
- R4: When a segment ends and link bit 1 is set, the channel issues five 4-byte reads (size code 2) at B+0x00, B+0x10, B+0x14, B+0x18 and B+0x1C, in that order, where B is the link with bits 4:0 cleared. These words become the link, count, source, destination and configuration. A link with bit 1 clear, including zero, ends the chain, and the link register (offset 0x00) then shows the last descriptor's link.
- R5: Each element is a read at the source address, with size code = configuration bits 13:12, followed by a write at the destination address, with size code = bits 17:16, carrying the data read. The count then drops by the source element size in bytes (1, 2, 4 or 8 for codes 0 to 3) and is clamped at zero.
- R6: Configuration bit 31 makes the source address step by its element size after each element, and bit 30 does the same for the destination. With the bit clear, the address stays fixed.
- R7: `xfer_done` pulses for one cycle only after the last descriptor's count reaches zero. At that point `busy` is low and configuration bit 0 reads 0.
- R8: A descriptor whose count is zero moves no data. The channel goes straight on to the link decision.
- R9: Writing the configuration with bit 0 clear while busy stops the channel at once. `busy` and `mem_req` drop, and no completion pulse follows.
- R10: An acknowledged access with `mem_err` high gives a one-cycle `xfer_err` pulse, stops the channel and clears configuration bit 0. There is no completion pulse.
- R11: While busy, writes to the link, count, source and destination registers are ignored, and so are configuration writes that keep bit 0 set.
- R12: A memory request keeps `mem_addr`, `mem_we` and `mem_size` stable until it is acknowledged with `mem_ack` in the same cycle as `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset inside the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size code (bytes = 1 << code) |
| mem_wdata | output | 64 | Write data, low bytes significant |
| mem_ack | input | 1 | Access accepted/completed this cycle |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| busy | output | 1 | Channel active |
| xfer_done | output | 1 | One-cycle chain-complete pulse |
| xfer_err | output | 1 | One-cycle error pulse |

## Verification
The copy engine is tried with a single 4-byte-element segment and with a three-descriptor chain that mixes 1-, 2- and 8-byte elements. The chain also has a count that is not a multiple of the element size, which separates correct clamping and fetch ordering from off-by-one decrement errors. A fixed-source pattern exposes any stepping of an address whose increment bit is clear. A zero-count head descriptor shows that a segment with nothing to move still chains. Abort, error-region and memory wait-state patterns tell a clean stop apart from a late completion pulse or a request that changes before it is acknowledged.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    // Register byte offsets inside one channel window
    localparam logic [5:0] OFF_LINK = 6'h00;
    localparam logic [5:0] OFF_CNT  = 6'h10;
    localparam logic [5:0] OFF_SRC  = 6'h14;
    localparam logic [5:0] OFF_DST  = 6'h18;
    localparam logic [5:0] OFF_CFG  = 6'h1C;
    localparam logic [5:0] OFF_STAT = 6'h20;

    // Configuration field positions
    localparam int CFG_EN     = 0;
    localparam int CFG_SINC   = 31;
    localparam int CFG_DINC   = 30;
    localparam int CFG_SW_LO  = 12;
    localparam int CFG_DW_LO  = 16;
    localparam int LINK_CHAIN = 1;

    // Number of descriptor words actually fetched (reserved words skipped)
    localparam int FETCH_WORDS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_READ,
        ST_WRITE
    } eng_state_e;

    // Software write strobes, one per writable register
    typedef struct packed {
        logic link;
        logic cnt;
        logic src;
        logic dst;
        logic cfg;
    } sw_wr_t;

    function automatic logic [3:0] width_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Byte offset of the n-th fetched descriptor word
    function automatic logic [4:0] fetch_off(input logic [2:0] idx);
        case (idx)
            3'd0:    return 5'h00;
            3'd1:    return 5'h10;
            3'd2:    return 5'h14;
            3'd3:    return 5'h18;
            default: return 5'h1C;
        endcase
    endfunction

endpackage

// File: rtl/lldma_regif.sv
module lldma_regif
    import lldma_pkg::*;
#(
    parameter int RA_W  = 6,
    parameter int AW    = 32,
    parameter int CNT_W = 13
) (
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [AW-1:0]    link_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [AW-1:0]    src_q,
    input  logic [AW-1:0]    dst_q,
    input  logic [31:0]      cfg_q,
    input  logic             busy,
    output sw_wr_t           sw_wr,
    output logic [31:0]      reg_rdata
);

    always_comb begin
        sw_wr      = '0;
        sw_wr.link = reg_we && (reg_addr == OFF_LINK);
        sw_wr.cnt  = reg_we && (reg_addr == OFF_CNT);
        sw_wr.src  = reg_we && (reg_addr == OFF_SRC);
        sw_wr.dst  = reg_we && (reg_addr == OFF_DST);
        sw_wr.cfg  = reg_we && (reg_addr == OFF_CFG);
    end

    always_comb begin
        case (reg_addr)
            OFF_LINK: reg_rdata = 32'(link_q);
            OFF_CNT:  reg_rdata = 32'(cnt_q);
            OFF_SRC:  reg_rdata = 32'(src_q);
            OFF_DST:  reg_rdata = 32'(dst_q);
            OFF_CFG:  reg_rdata = cfg_q;
            OFF_STAT: reg_rdata = {31'b0, busy};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  sw_wr_t           sw_wr,
    input  logic [31:0]      sw_wdata,
    output logic [AW-1:0]    link_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [AW-1:0]    src_q,
    output logic [AW-1:0]    dst_q,
    output logic [31:0]      cfg_q,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done_q,
    output logic             err_q
);

    localparam int FIDX_W = $clog2(FETCH_WORDS);

    eng_state_e       state;
    logic [AW-1:0]    fbase_q;
    logic [FIDX_W-1:0] fidx_q;
    logic [DW-1:0]    data_q;

    logic [1:0]       src_code, dst_code;
    logic [3:0]       src_bytes, dst_bytes;
    logic             abort, beat_ok, beat_bad;
    logic [31:0]      fword;

    assign src_code  = cfg_q[CFG_SW_LO +: 2];
    assign dst_code  = cfg_q[CFG_DW_LO +: 2];
    assign src_bytes = width_bytes(src_code);
    assign dst_bytes = width_bytes(dst_code);
    assign busy      = (state != ST_IDLE);
    assign abort     = busy && sw_wr.cfg && !sw_wdata[CFG_EN];
    assign beat_ok   = mem_req && mem_ack && !mem_err;
    assign beat_bad  = mem_req && mem_ack && mem_err;
    assign fword     = mem_rdata[31:0];

    // Memory master request generation
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = 2'd2;
        mem_wdata = data_q;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = fbase_q + AW'(fetch_off(3'(fidx_q)));
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
                mem_size = src_code;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
                mem_size = dst_code;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            link_q  <= '0;
            cnt_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cfg_q   <= '0;
            fbase_q <= '0;
            fidx_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (state == ST_IDLE) begin
                if (sw_wr.link) link_q <= AW'(sw_wdata);
                if (sw_wr.cnt)  cnt_q  <= sw_wdata[CNT_W-1:0];
                if (sw_wr.src)  src_q  <= AW'(sw_wdata);
                if (sw_wr.dst)  dst_q  <= AW'(sw_wdata);
                if (sw_wr.cfg) begin
                    cfg_q <= sw_wdata;
                    if (sw_wdata[CFG_EN]) state <= ST_CHECK;
                end
            end else if (abort) begin
                cfg_q <= sw_wdata;
                state <= ST_IDLE;
            end else if (beat_bad) begin
                err_q         <= 1'b1;
                cfg_q[CFG_EN] <= 1'b0;
                state         <= ST_IDLE;
            end else begin
                case (state)
                    ST_CHECK: begin
                        if (cnt_q != '0) begin
                            state <= ST_READ;
                        end else if (link_q[LINK_CHAIN]) begin
                            fbase_q <= {link_q[AW-1:5], 5'b0};
                            fidx_q  <= '0;
                            state   <= ST_FETCH;
                        end else begin
                            done_q        <= 1'b1;
                            cfg_q[CFG_EN] <= 1'b0;
                            state         <= ST_IDLE;
                        end
                    end
                    ST_FETCH: if (beat_ok) begin
                        fidx_q <= fidx_q + 1'b1;
                        case (fidx_q)
                            FIDX_W'(0): link_q <= AW'(fword);
                            FIDX_W'(1): cnt_q  <= fword[CNT_W-1:0];
                            FIDX_W'(2): src_q  <= AW'(fword);
                            FIDX_W'(3): dst_q  <= AW'(fword);
                            default: begin
                                cfg_q <= fword | 32'h1;
                                state <= ST_CHECK;
                            end
                        endcase
                    end
                    ST_READ: if (beat_ok) begin
                        data_q <= mem_rdata;
                        state  <= ST_WRITE;
                    end
                    ST_WRITE: if (beat_ok) begin
                        if (cfg_q[CFG_SINC]) src_q <= src_q + AW'(src_bytes);
                        if (cfg_q[CFG_DINC]) dst_q <= dst_q + AW'(dst_bytes);
                        cnt_q <= (cnt_q > CNT_W'(src_bytes)) ? cnt_q - CNT_W'(src_bytes) : '0;
                        state <= ST_CHECK;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Assertions
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size))); // R12

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && beat_ok && !abort) |=> (cnt_q < $past(cnt_q))); // R5

    AST_SRC_FIXED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && beat_ok && !abort && !cfg_q[CFG_SINC]) |=> $stable(src_q)); // R6

    AST_DONE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy && !cfg_q[CFG_EN] && !err_q)); // R7

    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !mem_req && !done_q)); // R9

    AST_ERR_STOP: assert property (@(posedge clk) disable iff (rst)
        (beat_bad && !abort) |=> (err_q && !busy && !cfg_q[CFG_EN])); // R10

    AST_LINK_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && sw_wr.link && state != ST_FETCH) |=> $stable(link_q)); // R11

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
    import lldma_pkg::*;
#(
    parameter int RA_W  = 6,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int CNT_W = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic            mem_err,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            xfer_done,
    output logic            xfer_err
);

    sw_wr_t           sw_wr;
    logic [AW-1:0]    link_q, src_q, dst_q;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      cfg_q;

    lldma_regif #(.RA_W(RA_W), .AW(AW), .CNT_W(CNT_W)) u_regif (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .link_q    (link_q),
        .cnt_q     (cnt_q),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cfg_q     (cfg_q),
        .busy      (busy),
        .sw_wr     (sw_wr),
        .reg_rdata (reg_rdata)
    );

    lldma_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sw_wr     (sw_wr),
        .sw_wdata  (reg_wdata),
        .link_q    (link_q),
        .cnt_q     (cnt_q),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cfg_q     (cfg_q),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .done_q    (xfer_done),
        .err_q     (xfer_err)
    );

endmodule

// File: tb/lldma_channel_test.sv
module lldma_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        busy, xfer_done, xfer_err;

    lldma_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .busy(busy), .xfer_done(xfer_done),
        .xfer_err(xfer_err)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [63:0] data;
        string       tag;
    } op_t;

    op_t         exp_q[$];
    logic [7:0]  mem [int unsigned];
    int          nchk = 0, nfail = 0;
    int          n_done = 0, n_err = 0;
    int          lat = 0, wcnt = 0;
    logic [31:0] h_addr;
    logic        h_we;
    logic [1:0]  h_sz;
    bit          finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [63:0] rd64(input logic [31:0] a);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = rdb(a + 32'(i));
        return v;
    endfunction

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return rd64(a)[31:0];
    endfunction

    task automatic put32(input logic [31:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[a + 32'(i)] = v[i*8 +: 8];
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] lk, input logic [31:0] c,
                            input logic [31:0] s, input logic [31:0] d, input logic [31:0] cf);
        put32(b, lk); put32(b + 32'h10, c); put32(b + 32'h14, s);
        put32(b + 32'h18, d); put32(b + 32'h1C, cf);
    endtask

    task automatic fill(input logic [31:0] a, input int n, input int seed);
        for (int i = 0; i < n; i++) mem[a + 32'(i)] = 8'(seed + i * 7);
    endtask

    function automatic logic [31:0] mkcfg(input bit si, input bit di, input logic [1:0] sw, input logic [1:0] dw);
        return (32'(si) << 31) | (32'(di) << 30) | (32'(sw) << 12) | (32'(dw) << 16) | 32'h1;
    endfunction

    // Behavioural model: expected memory operation sequence for a chain
    task automatic predict(input logic [31:0] lk, input logic [31:0] c, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] cf);
        op_t o;
        logic [31:0] b;
        int eb, db;
        c = c & 32'h1FFF;
        forever begin
            eb = 1 << cf[13:12];
            db = 1 << cf[17:16];
            while (c > 0) begin
                o.we = 0; o.addr = s; o.size = cf[13:12]; o.data = '0; o.tag = "R5";
                exp_q.push_back(o);
                o.we = 1; o.addr = d; o.size = cf[17:16]; o.data = rd64(s); o.tag = "R5";
                exp_q.push_back(o);
                if (cf[31]) s = s + 32'(eb);
                if (cf[30]) d = d + 32'(db);
                c = (c > 32'(eb)) ? c - 32'(eb) : 32'd0;
            end
            if (!lk[1]) break;
            b = lk & ~32'h1F;
            foreach (o.addr[i]) ;
            for (int k = 0; k < 5; k++) begin
                o.we = 0; o.size = 2'd2; o.data = '0; o.tag = "R4";
                o.addr = b + ((k == 0) ? 32'h0 : 32'h10 + 32'(4 * (k - 1)));
                exp_q.push_back(o);
            end
            lk = rd32(b); c = rd32(b + 32'h10) & 32'h1FFF; s = rd32(b + 32'h14);
            d = rd32(b + 32'h18); cf = rd32(b + 32'h1C);
        end
    endtask

    // Memory responder with configurable wait states
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 0; mem_err = 0; wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 0; mem_err = 0;
        end else if (!mem_req) begin
            wcnt = 0;
        end else if (wcnt < lat) begin
            if (wcnt == 0) begin
                h_addr = mem_addr; h_we = mem_we; h_sz = mem_size;
            end else begin
                check(mem_addr == h_addr && mem_we == h_we && mem_size == h_sz, "R12 request stable", 64'(mem_addr), 64'(h_addr));
            end
            wcnt++;
        end else begin
            wcnt = 0;
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected memory op", 64'(mem_addr), 64'hFFFFFFFF);
            end else begin
                op_t o;
                o = exp_q.pop_front();
                check(o.we == mem_we && o.addr == mem_addr && o.size == mem_size, o.tag,
                      {31'b0, mem_we, mem_addr}, {31'b0, o.we, o.addr});
                if (o.we) check(mem_wdata == o.data, "R5 write data", mem_wdata, o.data);
            end
            if (mem_addr >= 32'hF000_0000) begin
                mem_err = 1;
            end else if (mem_we) begin
                for (int i = 0; i < (1 << mem_size); i++) mem[mem_addr + 32'(i)] = mem_wdata[i*8 +: 8];
            end else begin
                mem_rdata = rd64(mem_addr);
            end
            mem_ack = 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && xfer_done) n_done++;
        if (!rst && xfer_err)  n_err++;
    end

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [31:0] lk, input logic [31:0] c, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] cf);
        reg_wr(6'h00, lk); reg_wr(6'h10, c); reg_wr(6'h14, s); reg_wr(6'h18, d);
        reg_wr(6'h1C, cf);
    endtask

    task automatic cmp_block(input logic [31:0] s, input logic [31:0] d, input int n, input string req);
        bit ok = 1;
        for (int i = 0; i < n; i++) if (rdb(s + 32'(i)) != rdb(d + 32'(i))) ok = 0;
        check(ok, req, 64'(ok), 64'd1);
    endtask

    initial begin
        logic [31:0] v;
        int d0, e0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        for (int a = 0; a <= 32; a += 4) begin
            reg_rd(6'(a), v);
            check(v == 32'h0, "R1 register reset value", 64'(v), 64'h0);
        end
        check(!busy && !mem_req && !xfer_done && !xfer_err, "R1 idle outputs", {busy, mem_req, xfer_done, xfer_err}, 0);

        // R2: count register width
        reg_wr(6'h10, 32'hFFFF);
        reg_rd(6'h10, v);
        check(v == 32'h1FFF, "R2 count clamp to 13 bits", 64'(v), 64'h1FFF);

        // Single segment, 4-byte elements, wait states (R3 R5 R6 R7 R12)
        lat = 2;
        fill(32'h1000, 16, 3);
        predict(32'h0, 32'd16, 32'h1000, 32'h2000, mkcfg(1, 1, 2'd2, 2'd2));
        start(32'h0, 32'd16, 32'h1000, 32'h2000, mkcfg(1, 1, 2'd2, 2'd2));
        check(busy == 1'b1, "R3 busy after start", 64'(busy), 64'd1);
        reg_rd(6'h20, v);
        check(v == 32'h1, "R3 status bit", 64'(v), 64'h1);
        wait_idle();
        check(n_done == 1 && n_err == 0, "R7 one completion pulse", 64'(n_done), 64'd1);
        check(exp_q.size() == 0, "R5 all operations issued", 64'(exp_q.size()), 64'd0);
        cmp_block(32'h1000, 32'h2000, 16, "R5 destination contents");
        reg_rd(6'h10, v);
        check(v == 32'h0, "R5 count at end", 64'(v), 64'h0);
        reg_rd(6'h1C, v);
        check(v[0] == 1'b0, "R7 enable cleared", 64'(v[0]), 64'd0);
        reg_rd(6'h14, v);
        check(v == 32'h1010, "R6 source stepped", 64'(v), 64'h1010);

        // Three-descriptor chain, mixed widths, odd count (R4 R5)
        lat = 0;
        d0 = n_done;
        fill(32'h1100, 5, 11); fill(32'h1200, 8, 21); fill(32'h1300, 8, 31);
        put_desc(32'h3000, 32'h3022, 32'd7, 32'h1200, 32'h2200, mkcfg(1, 1, 2'd1, 2'd1));
        put_desc(32'h3020, 32'h3040, 32'd3, 32'h1300, 32'h2300, mkcfg(1, 1, 2'd3, 2'd3));
        predict(32'h3002, 32'd5, 32'h1100, 32'h2100, mkcfg(1, 1, 2'd0, 2'd0));
        start(32'h3002, 32'd5, 32'h1100, 32'h2100, mkcfg(1, 1, 2'd0, 2'd0));
        wait_idle();
        check(n_done == d0 + 1, "R7 chain completes once", 64'(n_done - d0), 64'd1);
        check(exp_q.size() == 0, "R4 chain sequence consumed", 64'(exp_q.size()), 64'd0);
        reg_rd(6'h00, v);
        check(v == 32'h3040, "R4 link shows last descriptor link", 64'(v), 64'h3040);
        cmp_block(32'h1200, 32'h2200, 8, "R5 second segment data");
        cmp_block(32'h1300, 32'h2300, 8, "R5 third segment data");

        // Fixed source (R6)
        fill(32'h1400, 4, 41);
        predict(32'h0, 32'd12, 32'h1400, 32'h2400, mkcfg(0, 1, 2'd2, 2'd2));
        start(32'h0, 32'd12, 32'h1400, 32'h2400, mkcfg(0, 1, 2'd2, 2'd2));
        wait_idle();
        reg_rd(6'h14, v);
        check(v == 32'h1400, "R6 fixed source unchanged", 64'(v), 64'h1400);
        reg_rd(6'h18, v);
        check(v == 32'h240C, "R6 destination stepped", 64'(v), 64'h240C);

        // Zero-count head descriptor chains immediately (R8)
        d0 = n_done;
        fill(32'h1500, 4, 51);
        put_desc(32'h3100, 32'h0, 32'd4, 32'h1500, 32'h2500, mkcfg(1, 1, 2'd0, 2'd0));
        predict(32'h3102, 32'd0, 32'h9000, 32'h9100, mkcfg(1, 1, 2'd0, 2'd0));
        start(32'h3102, 32'd0, 32'h9000, 32'h9100, mkcfg(1, 1, 2'd0, 2'd0));
        wait_idle();
        check(exp_q.size() == 0 && n_done == d0 + 1, "R8 zero count moves nothing", 64'(exp_q.size()), 64'd0);
        cmp_block(32'h1500, 32'h2500, 4, "R8 following segment data");

        // Writes ignored while busy, then abort (R11 R9)
        lat = 1;
        d0 = n_done;
        fill(32'h1600, 64, 61);
        predict(32'h0, 32'd64, 32'h1600, 32'h2600, mkcfg(1, 1, 2'd0, 2'd0));
        start(32'h0, 32'd64, 32'h1600, 32'h2600, mkcfg(1, 1, 2'd0, 2'd0));
        reg_wr(6'h00, 32'h7777);
        reg_rd(6'h00, v);
        check(v == 32'h0, "R11 link write ignored while busy", 64'(v), 64'h0);
        reg_wr(6'h1C, mkcfg(1, 1, 2'd3, 2'd3));
        reg_rd(6'h1C, v);
        check(v == mkcfg(1, 1, 2'd0, 2'd0), "R11 config write ignored while busy", 64'(v), 64'(mkcfg(1, 1, 2'd0, 2'd0)));
        repeat (10) @(negedge clk);
        reg_wr(6'h1C, 32'h0);
        check(!busy && !mem_req, "R9 stop after abort", {busy, mem_req}, 0);
        repeat (5) begin
            @(negedge clk);
            check(!mem_req && !busy, "R9 stays stopped", {busy, mem_req}, 0);
        end
        check(n_done == d0, "R9 no completion after abort", 64'(n_done - d0), 64'd0);
        exp_q.delete();

        // Error response (R10)
        lat = 0;
        d0 = n_done; e0 = n_err;
        begin
            op_t o;
            o.we = 0; o.addr = 32'hF000_0000; o.size = 2'd2; o.data = '0; o.tag = "R10";
            exp_q.push_back(o);
        end
        start(32'h0, 32'd8, 32'hF000_0000, 32'h2700, mkcfg(1, 1, 2'd2, 2'd2));
        wait_idle();
        check(n_err == e0 + 1 && n_done == d0, "R10 error pulse without completion", 64'(n_err - e0), 64'd1);
        reg_rd(6'h1C, v);
        check(v[0] == 1'b0 && !busy, "R10 channel stopped", 64'(v[0]), 64'd0);
        check(exp_q.size() == 0, "R10 no further operations", 64'(exp_q.size()), 64'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule